// File: doc/BRIEF.md
# AXI-Lite Address-Decoding Mux

This block connects a single AXI-Lite master to a set of N register-bus slave ports. Each request address is compared against a parameter table of power-of-two aligned regions. The request then goes to the one slave whose region holds the address. The read side and the write side have separate decode logic and separate selection state, so a read and a write can be in flight at the same time, even to different ports.

An address that falls in no region is never forwarded. The block answers it itself with a decode-error response. It still completes every handshake the master expects, so the master is never left waiting.

Each direction carries at most one transaction at a time. The chosen port stays locked from the address handshake until the master accepts the response. This relies on the master not queuing a second request before the first has completed. Register-bus masters that convert from full AXI behave this way. The data path is a decode compare followed by a select, which keeps the logic depth shallow.

Top module: `axil_route_mux`

## Requirements
- R1: A read or write address whose bits above `SPAN_BITS[i]` equal those of `BASE_ADDRS[i]` is routed to slave port i. The default map is port 0 at 0x0000-0x0FFF, port 1 at 0x1000-0x1FFF and port 2 at 0x4000-0x7FFF.
- R2: A read address in no region is accepted by the block itself and answered with exactly one R beat carrying RRESP = 2'b11 and RDATA = 0.
- R3: A write address in no region has both its AW and W transfers accepted by the block and is answered with one B beat carrying BRESP = 2'b11. No slave port sees the request.
- R4: For a routed transaction, the selected slave's RDATA/RRESP and BRESP reach the master unchanged, including a slave error code of 2'b10.
- R5: Only the selected port sees AWVALID, WVALID or ARVALID. RREADY and BREADY reach only the selected port, and only while the master drives them.
- R6: After an AR handshake, ARREADY stays low until the matching R handshake has completed. After an AW handshake, AWREADY stays low until the matching B handshake has completed.
- R7: The read and write directions proceed independently. A read and a write that overlap in time both complete with correct results.
- R8: WREADY stays low while AWVALID is low and no write is in progress. Write data goes to the port selected by the write address, whichever of AW and W arrives first.
- R9: Once RVALID or BVALID is high, it stays high with a stable payload until the master accepts it.
- R10: While reset is asserted, the block drives no VALID toward the master or toward any slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_awaddr | input | ADDR_W | Master write address |
| m_awvalid | input | 1 | Master write address valid |
| m_awready | output | 1 | Write address accepted |
| m_wdata | input | DATA_W | Master write data |
| m_wstrb | input | STRB_W | Master write byte enables |
| m_wvalid | input | 1 | Master write data valid |
| m_wready | output | 1 | Write data accepted |
| m_bresp | output | 2 | Write response code |
| m_bvalid | output | 1 | Write response valid |
| m_bready | input | 1 | Master accepts write response |
| m_araddr | input | ADDR_W | Master read address |
| m_arvalid | input | 1 | Master read address valid |
| m_arready | output | 1 | Read address accepted |
| m_rdata | output | DATA_W | Read data to master |
| m_rresp | output | 2 | Read response code |
| m_rvalid | output | 1 | Read data valid |
| m_rready | input | 1 | Master accepts read data |
| s_awaddr | output | N_PORTS x ADDR_W | Write address per port |
| s_awvalid | output | N_PORTS | Write address valid per port |
| s_awready | input | N_PORTS | Write address ready per port |
| s_wdata | output | N_PORTS x DATA_W | Write data per port |
| s_wstrb | output | N_PORTS x STRB_W | Byte enables per port |
| s_wvalid | output | N_PORTS | Write data valid per port |
| s_wready | input | N_PORTS | Write data ready per port |
| s_bresp | input | N_PORTS x 2 | Write response code per port |
| s_bvalid | input | N_PORTS | Write response valid per port |
| s_bready | output | N_PORTS | Write response ready per port |
| s_araddr | output | N_PORTS x ADDR_W | Read address per port |
| s_arvalid | output | N_PORTS | Read address valid per port |
| s_arready | input | N_PORTS | Read address ready per port |
| s_rdata | input | N_PORTS x DATA_W | Read data per port |
| s_rresp | input | N_PORTS x 2 | Read response code per port |
| s_rvalid | input | N_PORTS | Read data valid per port |
| s_rready | output | N_PORTS | Read data ready per port |

## Verification
The hardest case to reach from the ports is a write whose address and data handshakes happen on different cycles. This matters most for a decode miss, where the block must accept W after it has already taken AW and only then raise its own B. The bench gets there with three write orderings (data first, address first and both together) and a slave model on port 2 that accepts AW and W separately. Each ordering is aimed at routed and unmatched addresses alike. A second hard case is a read and a write in flight together; the bench issues them from concurrent threads. A per-cycle model of both directions' busy state checks every routed VALID and READY throughout.

// File: rtl/axil_route_pkg.sv
package axil_route_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BUSY = 2'd1,
    PH_ERR  = 2'd2
  } phase_t;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_DECERR = 2'b11;

endpackage

// File: rtl/axil_route_decode.sv
module axil_route_decode #(
  parameter int N_PORTS = 3,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 2,
  parameter logic [N_PORTS-1:0][ADDR_W-1:0] BASE_ADDRS = '0,
  parameter logic [N_PORTS-1:0][7:0]        SPAN_BITS  = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  logic [N_PORTS-1:0] match;

  // one region compare per port: only bits above the region size count
  generate
    for (genvar g = 0; g < N_PORTS; g++) begin : g_cmp
      localparam int unsigned SPAN = SPAN_BITS[g];
      localparam logic [ADDR_W-1:0] KEEP =
        (SPAN >= ADDR_W) ? '0 : ~((ADDR_W'(1) << SPAN) - ADDR_W'(1));
      assign match[g] = ((addr ^ BASE_ADDRS[g]) & KEEP) == '0;
    end
  endgenerate

  // lowest index wins if regions were ever configured to overlap
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N_PORTS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/axil_route_rd.sv
module axil_route_rd
  import axil_route_pkg::*;
#(
  parameter int N_PORTS = 3,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             dec_hit,
  input  logic [IDX_W-1:0]                 dec_idx,
  input  logic                             m_arvalid,
  output logic                             m_arready,
  output logic [DATA_W-1:0]                m_rdata,
  output logic [1:0]                       m_rresp,
  output logic                             m_rvalid,
  input  logic                             m_rready,
  output logic [N_PORTS-1:0]               s_arvalid,
  input  logic [N_PORTS-1:0]               s_arready,
  input  logic [N_PORTS-1:0][DATA_W-1:0]   s_rdata,
  input  logic [N_PORTS-1:0][1:0]          s_rresp,
  input  logic [N_PORTS-1:0]               s_rvalid,
  output logic [N_PORTS-1:0]               s_rready
);

  phase_t           phase_q, phase_d;
  logic [IDX_W-1:0] sel_q, sel_d;
  logic             phase_en, sel_en;

  // next-state and channel steering
  always_comb begin
    phase_d   = phase_q;
    sel_d     = sel_q;
    m_arready = 1'b0;
    m_rvalid  = 1'b0;
    m_rdata   = '0;
    m_rresp   = RESP_OKAY;
    s_arvalid = '0;
    s_rready  = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (dec_hit) begin
          s_arvalid[dec_idx] = m_arvalid;
          m_arready          = s_arready[dec_idx];
          if (m_arvalid && s_arready[dec_idx]) begin
            phase_d = PH_BUSY;
            sel_d   = dec_idx;
          end
        end else begin
          m_arready = 1'b1;
          if (m_arvalid) begin
            phase_d = PH_ERR;
          end
        end
      end
      PH_BUSY: begin
        m_rvalid        = s_rvalid[sel_q];
        m_rdata         = s_rdata[sel_q];
        m_rresp         = s_rresp[sel_q];
        s_rready[sel_q] = m_rready;
        if (s_rvalid[sel_q] && m_rready) begin
          phase_d = PH_IDLE;
        end
      end
      PH_ERR: begin
        m_rvalid = 1'b1;
        m_rresp  = RESP_DECERR;
        if (m_rready) begin
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  assign phase_en = (phase_d != phase_q);
  assign sel_en   = (phase_q == PH_IDLE) && m_arvalid && dec_hit && s_arready[dec_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      sel_q   <= '0;
    end else begin
      if (phase_en) phase_q <= phase_d;
      if (sel_en)   sel_q   <= sel_d;
    end
  end

endmodule

// File: rtl/axil_route_wr.sv
module axil_route_wr
  import axil_route_pkg::*;
#(
  parameter int N_PORTS = 3,
  parameter int IDX_W   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dec_hit,
  input  logic [IDX_W-1:0]        dec_idx,
  input  logic                    m_awvalid,
  output logic                    m_awready,
  input  logic                    m_wvalid,
  output logic                    m_wready,
  output logic [1:0]              m_bresp,
  output logic                    m_bvalid,
  input  logic                    m_bready,
  output logic [N_PORTS-1:0]      s_awvalid,
  input  logic [N_PORTS-1:0]      s_awready,
  output logic [N_PORTS-1:0]      s_wvalid,
  input  logic [N_PORTS-1:0]      s_wready,
  input  logic [N_PORTS-1:0][1:0] s_bresp,
  input  logic [N_PORTS-1:0]      s_bvalid,
  output logic [N_PORTS-1:0]      s_bready
);

  phase_t           phase_q, phase_d;
  logic [IDX_W-1:0] sel_q, sel_d;
  logic             wdone_q, wdone_d;
  logic             aw_hs, w_hs, b_hs;
  logic             phase_en, sel_en, wdone_en;

  always_comb begin
    phase_d   = phase_q;
    sel_d     = sel_q;
    m_awready = 1'b0;
    m_wready  = 1'b0;
    m_bvalid  = 1'b0;
    m_bresp   = RESP_OKAY;
    s_awvalid = '0;
    s_wvalid  = '0;
    s_bready  = '0;
    aw_hs     = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (dec_hit) begin
          s_awvalid[dec_idx] = m_awvalid;
          m_awready          = s_awready[dec_idx];
          aw_hs              = m_awvalid && s_awready[dec_idx];
          // data may travel with the address, steered by the same decode
          if (m_awvalid && !wdone_q) begin
            s_wvalid[dec_idx] = m_wvalid;
            m_wready          = s_wready[dec_idx];
          end
        end else begin
          m_awready = 1'b1;
          aw_hs     = m_awvalid;
          if (m_awvalid && !wdone_q) begin
            m_wready = 1'b1;
          end
        end
        if (aw_hs) begin
          phase_d = dec_hit ? PH_BUSY : PH_ERR;
          sel_d   = dec_idx;
        end
      end
      PH_BUSY: begin
        if (!wdone_q) begin
          s_wvalid[sel_q] = m_wvalid;
          m_wready        = s_wready[sel_q];
        end
        m_bvalid        = s_bvalid[sel_q];
        m_bresp         = s_bresp[sel_q];
        s_bready[sel_q] = m_bready;
        if (s_bvalid[sel_q] && m_bready) begin
          phase_d = PH_IDLE;
        end
      end
      PH_ERR: begin
        if (!wdone_q) begin
          m_wready = 1'b1;
        end
        m_bvalid = wdone_q;
        m_bresp  = RESP_DECERR;
        if (wdone_q && m_bready) begin
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  assign w_hs     = m_wvalid && m_wready;
  assign b_hs     = m_bvalid && m_bready;
  assign wdone_d  = b_hs ? 1'b0 : 1'b1;
  assign wdone_en = b_hs || w_hs;
  assign phase_en = (phase_d != phase_q);
  assign sel_en   = aw_hs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      sel_q   <= '0;
      wdone_q <= 1'b0;
    end else begin
      if (phase_en) phase_q <= phase_d;
      if (sel_en)   sel_q   <= sel_d;
      if (wdone_en) wdone_q <= wdone_d;
    end
  end

endmodule

// File: rtl/axil_route_mux.sv
module axil_route_mux #(
  parameter int N_PORTS = 3,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int STRB_W  = DATA_W / 8,
  parameter logic [N_PORTS-1:0][ADDR_W-1:0] BASE_ADDRS =
    {32'h0000_4000, 32'h0000_1000, 32'h0000_0000},
  parameter logic [N_PORTS-1:0][7:0] SPAN_BITS = {8'd14, 8'd12, 8'd12}
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               m_awaddr,
  input  logic                            m_awvalid,
  output logic                            m_awready,
  input  logic [DATA_W-1:0]               m_wdata,
  input  logic [STRB_W-1:0]               m_wstrb,
  input  logic                            m_wvalid,
  output logic                            m_wready,
  output logic [1:0]                      m_bresp,
  output logic                            m_bvalid,
  input  logic                            m_bready,
  input  logic [ADDR_W-1:0]               m_araddr,
  input  logic                            m_arvalid,
  output logic                            m_arready,
  output logic [DATA_W-1:0]               m_rdata,
  output logic [1:0]                      m_rresp,
  output logic                            m_rvalid,
  input  logic                            m_rready,
  output logic [N_PORTS-1:0][ADDR_W-1:0]  s_awaddr,
  output logic [N_PORTS-1:0]              s_awvalid,
  input  logic [N_PORTS-1:0]              s_awready,
  output logic [N_PORTS-1:0][DATA_W-1:0]  s_wdata,
  output logic [N_PORTS-1:0][STRB_W-1:0]  s_wstrb,
  output logic [N_PORTS-1:0]              s_wvalid,
  input  logic [N_PORTS-1:0]              s_wready,
  input  logic [N_PORTS-1:0][1:0]         s_bresp,
  input  logic [N_PORTS-1:0]              s_bvalid,
  output logic [N_PORTS-1:0]              s_bready,
  output logic [N_PORTS-1:0][ADDR_W-1:0]  s_araddr,
  output logic [N_PORTS-1:0]              s_arvalid,
  input  logic [N_PORTS-1:0]              s_arready,
  input  logic [N_PORTS-1:0][DATA_W-1:0]  s_rdata,
  input  logic [N_PORTS-1:0][1:0]         s_rresp,
  input  logic [N_PORTS-1:0]              s_rvalid,
  output logic [N_PORTS-1:0]              s_rready
);

  localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

  logic             rd_hit, wr_hit;
  logic [IDX_W-1:0] rd_idx, wr_idx;

  // payload fans out to every port; only the VALIDs are steered
  generate
    for (genvar p = 0; p < N_PORTS; p++) begin : g_fan
      assign s_awaddr[p] = m_awaddr;
      assign s_araddr[p] = m_araddr;
      assign s_wdata[p]  = m_wdata;
      assign s_wstrb[p]  = m_wstrb;
    end
  endgenerate

  axil_route_decode #(
    .N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .BASE_ADDRS(BASE_ADDRS), .SPAN_BITS(SPAN_BITS)
  ) u_rd_dec (
    .addr(m_araddr), .hit(rd_hit), .idx(rd_idx)
  );

  axil_route_decode #(
    .N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .BASE_ADDRS(BASE_ADDRS), .SPAN_BITS(SPAN_BITS)
  ) u_wr_dec (
    .addr(m_awaddr), .hit(wr_hit), .idx(wr_idx)
  );

  axil_route_rd #(
    .N_PORTS(N_PORTS), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_rd (
    .clk(clk), .rst_n(rst_n),
    .dec_hit(rd_hit), .dec_idx(rd_idx),
    .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready),
    .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready)
  );

  axil_route_wr #(
    .N_PORTS(N_PORTS), .IDX_W(IDX_W)
  ) u_wr (
    .clk(clk), .rst_n(rst_n),
    .dec_hit(wr_hit), .dec_idx(wr_idx),
    .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready)
  );

endmodule

// File: rtl/axil_route_mux_chk.sv
module axil_route_mux_chk #(
  parameter int N_PORTS = 3,
  parameter int DATA_W  = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                m_awvalid,
  input logic                m_awready,
  input logic [1:0]          m_bresp,
  input logic                m_bvalid,
  input logic                m_bready,
  input logic                m_arvalid,
  input logic                m_arready,
  input logic [DATA_W-1:0]   m_rdata,
  input logic [1:0]          m_rresp,
  input logic                m_rvalid,
  input logic                m_rready,
  input logic [N_PORTS-1:0]  s_awvalid,
  input logic [N_PORTS-1:0]  s_wvalid,
  input logic [N_PORTS-1:0]  s_bvalid,
  input logic [N_PORTS-1:0]  s_bready,
  input logic [N_PORTS-1:0]  s_arvalid,
  input logic [N_PORTS-1:0]  s_rvalid,
  input logic [N_PORTS-1:0]  s_rready
);

  // R5: at most one port addressed at a time, readies only when the master is ready
  a_r5_ar_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(s_arvalid));
  a_r5_aw_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(s_awvalid));
  a_r5_w_onehot:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0(s_wvalid));
  a_r5_rready_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_rready) && ((|s_rready) -> m_rready));
  a_r5_bready_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_bready) && ((|s_bready) -> m_bready));

  // R2: a read beat no slave offers must be the local decode error
  a_r2_local_rresp: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rvalid && (s_rvalid == '0)) |-> (m_rresp == 2'b11 && m_rdata == '0));

  // R3: a write response no slave offers must be the local decode error
  a_r3_local_bresp: assert property (@(posedge clk) disable iff (!rst_n)
    (m_bvalid && (s_bvalid == '0)) |-> (m_bresp == 2'b11));

  // R6: one transaction per direction
  a_r6_ar_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && m_arready) |=> !m_arready);
  a_r6_aw_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid && m_awready) |=> !m_awready);

  // R9: responses are held until taken
  a_r9_rvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rvalid && !m_rready) |=> (m_rvalid && $stable(m_rdata) && $stable(m_rresp)));
  a_r9_bvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_bvalid && !m_bready) |=> (m_bvalid && $stable(m_bresp)));

endmodule

bind axil_route_mux axil_route_mux_chk #(.N_PORTS(N_PORTS), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_axil_route_mux.sv
`timescale 1ns/1ps
module sim_axil_route_mux;

  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic [31:0] m_awaddr, m_wdata, m_araddr, m_rdata;
  logic [3:0]  m_wstrb;
  logic        m_awvalid, m_awready, m_wvalid, m_wready, m_bvalid, m_bready;
  logic        m_arvalid, m_arready, m_rvalid, m_rready;
  logic [1:0]  m_bresp, m_rresp;
  logic [NP-1:0][31:0] s_awaddr, s_wdata, s_araddr, s_rdata;
  logic [NP-1:0][3:0]  s_wstrb;
  logic [NP-1:0][1:0]  s_bresp, s_rresp;
  logic [NP-1:0] s_awvalid, s_awready, s_wvalid, s_wready, s_bvalid, s_bready;
  logic [NP-1:0] s_arvalid, s_arready, s_rvalid, s_rready;

  axil_route_mux u0 (.*);

  // ---------------- checking infrastructure ----------------
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // bench-side memory map (independent of the RTL parameters)
  function automatic int exp_port(input logic [31:0] a);
    if (a < 32'h1000) return 0;
    if (a < 32'h2000) return 1;
    if (a >= 32'h4000 && a < 32'h8000) return 2;
    return -1;
  endfunction

  function automatic logic [NP-1:0] port_bit(input int p);
    return (p < 0) ? '0 : NP'(1) << p;
  endfunction

  // ---------------- slave models ----------------
  logic [31:0] mem [NP][16];
  logic [31:0] emem [NP][16];
  logic [NP-1:0] rpend, bpend, aw_got, w_got;
  logic [NP-1:0][31:0] rdat, awa, wd;
  logic [NP-1:0][1:0] rrsp, brsp;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      s_arready[p] = !rpend[p];
      if (p == 2) begin
        s_awready[p] = !bpend[p] && !aw_got[p];
        s_wready[p]  = !bpend[p] && !w_got[p];
      end else begin
        s_awready[p] = !bpend[p] && s_wvalid[p];
        s_wready[p]  = !bpend[p] && s_awvalid[p];
      end
    end
  end
  assign s_rvalid = rpend;
  assign s_rdata  = rdat;
  assign s_rresp  = rrsp;
  assign s_bvalid = bpend;
  assign s_bresp  = brsp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++)
        for (int i = 0; i < 16; i++) mem[p][i] <= 32'(p * 256 + i);
      rpend <= '0; bpend <= '0; aw_got <= '0; w_got <= '0;
      rdat <= '0; awa <= '0; wd <= '0; rrsp <= '0; brsp <= '0;
    end else begin
      for (int p = 0; p < NP; p++) begin : slv
        logic aw_now, w_now;
        logic [31:0] a_v, d_v;
        aw_now = s_awvalid[p] && s_awready[p];
        w_now  = s_wvalid[p] && s_wready[p];
        if (s_arvalid[p] && s_arready[p]) begin
          rpend[p] <= 1'b1;
          rdat[p]  <= mem[p][s_araddr[p][5:2]];
          rrsp[p]  <= (s_araddr[p][11:0] == 12'h040) ? 2'b10 : 2'b00;
        end else if (rpend[p] && s_rready[p]) begin
          rpend[p] <= 1'b0;
        end
        if (aw_now) begin aw_got[p] <= 1'b1; awa[p] <= s_awaddr[p]; end
        if (w_now)  begin w_got[p]  <= 1'b1; wd[p]  <= s_wdata[p];  end
        if ((aw_got[p] || aw_now) && (w_got[p] || w_now)) begin
          a_v = aw_now ? s_awaddr[p] : awa[p];
          d_v = w_now ? s_wdata[p] : wd[p];
          if (a_v[11:0] != 12'h044) mem[p][a_v[5:2]] <= d_v;
          brsp[p]   <= (a_v[11:0] == 12'h044) ? 2'b10 : 2'b00;
          bpend[p]  <= 1'b1;
          aw_got[p] <= 1'b0;
          w_got[p]  <= 1'b0;
        end
        if (bpend[p] && s_bready[p]) bpend[p] <= 1'b0;
      end
    end
  end

  // ---------------- per-cycle reference model ----------------
  bit rd_busy = 0, wr_busy = 0;
  int rd_sel = -1, wr_sel = -1;

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && !done) begin
        chk(s_arvalid == ((!rd_busy && m_arvalid) ? port_bit(exp_port(m_araddr)) : '0),
            "R5", "s_arvalid", 32'(s_arvalid),
            32'((!rd_busy && m_arvalid) ? port_bit(exp_port(m_araddr)) : '0));
        chk(s_awvalid == ((!wr_busy && m_awvalid) ? port_bit(exp_port(m_awaddr)) : '0),
            "R5", "s_awvalid", 32'(s_awvalid),
            32'((!wr_busy && m_awvalid) ? port_bit(exp_port(m_awaddr)) : '0));
        chk(s_rready == ((rd_busy && m_rready) ? port_bit(rd_sel) : '0),
            "R5", "s_rready", 32'(s_rready),
            32'((rd_busy && m_rready) ? port_bit(rd_sel) : '0));
        chk(s_bready == ((wr_busy && m_bready) ? port_bit(wr_sel) : '0),
            "R5", "s_bready", 32'(s_bready),
            32'((wr_busy && m_bready) ? port_bit(wr_sel) : '0));
        chk(!(rd_busy && m_arready), "R6", "arready while busy", 32'(m_arready), 32'h0);
        chk(!(wr_busy && m_awready), "R6", "awready while busy", 32'(m_awready), 32'h0);
        // apply the handshakes that the coming edge will perform
        if (m_arvalid && m_arready) begin rd_busy = 1; rd_sel = exp_port(m_araddr); end
        else if (m_rvalid && m_rready) rd_busy = 0;
        if (m_awvalid && m_awready) begin wr_busy = 1; wr_sel = exp_port(m_awaddr); end
        else if (m_bvalid && m_bready) wr_busy = 0;
      end
    end
  end

  // ---------------- master tasks ----------------
  task automatic do_read(input logic [31:0] a, input logic [31:0] exp_d,
                         input logic [1:0] exp_r, input int stall, input string req);
    logic hs;
    logic [31:0] first;
    @(negedge clk);
    m_araddr = a; m_arvalid = 1'b1;
    forever begin
      #1; hs = m_arready;
      @(negedge clk);
      if (hs) begin m_arvalid = 1'b0; break; end
    end
    forever begin
      #1; if (m_rvalid) break;
      @(negedge clk);
    end
    first = m_rdata;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk); #1;
      chk(m_rvalid && m_rdata == first, "R9", "rdata held under backpressure", m_rdata, first);
    end
    @(negedge clk);
    m_rready = 1'b1;
    #1;
    chk(m_rvalid && m_rdata == exp_d, req, "rdata", m_rdata, exp_d);
    chk(m_rresp == exp_r, req, "rresp", 32'(m_rresp), 32'(exp_r));
    @(negedge clk);
    m_rready = 1'b0;
  endtask

  // mode 0: AW and W together, 1: W first, 2: AW first
  task automatic do_write(input logic [31:0] a, input logic [31:0] d, input int mode,
                          input logic [1:0] exp_r, input string req);
    bit a_hs, w_hs, started;
    int cyc = 0;
    @(negedge clk);
    m_awaddr = a; m_wdata = d; m_wstrb = 4'hF;
    if (mode == 1) begin
      m_wvalid = 1'b1;
      for (int k = 0; k < 3; k++) begin
        #1; chk(!m_wready, "R8", "wready before AW", 32'(m_wready), 32'h0);
        @(negedge clk);
      end
    end
    m_awvalid = 1'b1;
    if (mode == 0) m_wvalid = 1'b1;
    started = (mode != 2);
    forever begin
      #1;
      a_hs = m_awvalid && m_awready;
      w_hs = m_wvalid && m_wready;
      @(negedge clk);
      cyc++;
      if (a_hs) m_awvalid = 1'b0;
      if (w_hs) m_wvalid = 1'b0;
      if (!started && cyc >= 2) begin m_wvalid = 1'b1; started = 1; end
      if (started && !m_awvalid && !m_wvalid) break;
    end
    m_bready = 1'b1;
    forever begin
      #1; if (m_bvalid) break;
      @(negedge clk);
    end
    chk(m_bresp == exp_r, req, "bresp", 32'(m_bresp), 32'(exp_r));
    @(negedge clk);
    m_bready = 1'b0;
    if (exp_r == 2'b00) emem[exp_port(a)][a[5:2]] = d;
  endtask

  function automatic logic [31:0] ev(input logic [31:0] a);
    return emem[exp_port(a)][a[5:2]];
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < 16; i++) emem[p][i] = 32'(p * 256 + i);
    m_awaddr = '0; m_awvalid = 0; m_wdata = '0; m_wstrb = '0; m_wvalid = 0; m_bready = 0;
    m_araddr = '0; m_arvalid = 0; m_rready = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R10: reset state
    chk(!m_rvalid && !m_bvalid, "R10", "master valids in reset", {30'h0, m_rvalid, m_bvalid}, 32'h0);
    chk(s_arvalid == '0 && s_awvalid == '0 && s_wvalid == '0, "R10", "slave valids in reset",
        32'({s_arvalid, s_awvalid, s_wvalid}), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1/R8: routed writes in every ordering
    do_write(32'h0000_0010, 32'hA5A5_0001, 0, 2'b00, "R1");
    do_write(32'h0000_1FFC, 32'hA5A5_0002, 2, 2'b00, "R1");
    do_write(32'h0000_4100, 32'hA5A5_0003, 2, 2'b00, "R8");
    do_write(32'h0000_7FFC, 32'hA5A5_0004, 1, 2'b00, "R8");

    // R1/R4: read back through the routing
    do_read(32'h0000_0010, ev(32'h0000_0010), 2'b00, 0, "R1");
    do_read(32'h0000_1FFC, ev(32'h0000_1FFC), 2'b00, 0, "R1");
    do_read(32'h0000_4100, ev(32'h0000_4100), 2'b00, 0, "R1");
    do_read(32'h0000_7FFC, ev(32'h0000_7FFC), 2'b00, 1, "R8");
    do_read(32'h0000_1004, ev(32'h0000_1004), 2'b00, 3, "R9");

    // R4: slave error codes pass through
    do_read(32'h0000_1040, ev(32'h0000_1040), 2'b10, 0, "R4");
    do_write(32'h0000_0044, 32'hDEAD_0044, 0, 2'b10, "R4");
    do_read(32'h0000_0004, ev(32'h0000_0004), 2'b00, 0, "R4");

    // R2: read decode misses, one with backpressure
    do_read(32'h0000_2000, 32'h0, 2'b11, 2, "R2");
    do_read(32'hFFFF_0000, 32'h0, 2'b11, 0, "R2");
    do_read(32'h0000_8000, 32'h0, 2'b11, 0, "R2");

    // R3: write decode misses in all orderings, nothing reaches a slave
    do_write(32'h0000_8000, 32'hBAD0_0001, 0, 2'b11, "R3");
    do_write(32'h0000_3000, 32'hBAD0_0002, 1, 2'b11, "R3");
    do_write(32'h0000_9000, 32'hBAD0_0003, 2, 2'b11, "R3");
    do_read(32'h0000_0000, ev(32'h0000_0000), 2'b00, 0, "R3");
    do_read(32'h0000_4000, ev(32'h0000_4000), 2'b00, 0, "R3");
    do_read(32'h0000_1000, ev(32'h0000_1000), 2'b00, 0, "R3");

    // R7: overlapping read and write
    fork
      do_write(32'h0000_0020, 32'hC0DE_0020, 0, 2'b00, "R7");
      do_read(32'h0000_1008, ev(32'h0000_1008), 2'b00, 2, "R7");
    join
    fork
      do_write(32'h0000_A000, 32'hBAD0_0004, 2, 2'b11, "R7");
      do_read(32'h0000_4008, ev(32'h0000_4008), 2'b00, 0, "R7");
    join
    fork
      do_write(32'h0000_4008, 32'hC0DE_4008, 1, 2'b00, "R7");
      do_read(32'h0000_2004, 32'h0, 2'b11, 1, "R7");
    join
    do_read(32'h0000_0020, ev(32'h0000_0020), 2'b00, 0, "R7");
    do_read(32'h0000_4008, ev(32'h0000_4008), 2'b00, 0, "R7");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule